// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Array

This block holds the message-signalled interrupt vector table of a PCIe-style function with `N` vectors. Each vector has a 64-bit message address, a 32-bit message data word and a mask bit. The block also holds the pending bits for the vectors and a small message control register with an enable bit and a function-wide mask bit. Software reaches the table and the pending array through a simple register bus. Each access carries an address, a length of 4 or 8 bytes, write data and a registered read result. The two windows sit inside the memory space of a selectable base address register. Each window has a location word: its low three bits pick the base register and the remaining bits give the offset.

Per-vector interrupt requests set pending bits. When a pending vector is free to fire, the block emits one message per cycle on its output. The message carries the vector's address and data, and sending it clears the pending bit. Vectors are served lowest number first. A 64-bit write that covers both message data and vector control is accepted only while the vector cannot fire. This stops a half-updated message from being sent.

Top module: `msix_vector_block`

## Requirements
- R1: An access is legal only with length 4 at a 4-byte-aligned address or length 8 at an 8-byte-aligned address. An illegal read returns all ones (64 bits) and an illegal write changes nothing.
- R2: Table entry `v` occupies 16 bytes at table base + 16·v. The low address word is at byte offset 0, the high address word at 4, message data at 8 and vector control at 12. Vector control bit 0 is the mask, and a 4-byte read returns zeros in bits 63:32.
- R3: A 4-byte write at offset 0 replaces address bits 31:0 and keeps bits 63:32. An 8-byte write at offset 0 replaces all 64 address bits.
- R4: An 8-byte read at offset 8 returns message data in bits 31:0 and vector control in bits 63:32.
- R5: An 8-byte write at offset 8 writes data from bits 31:0 and the mask from bit 32. It is discarded entirely when the vector is unmasked, the function mask is clear and the enable is set.
- R6: After reset every vector's mask is 1, addresses and data are 0, no bit is pending, and enable and function mask are 0.
- R7: The pending window is ceil(N/8) bytes at its base. Bit `v` of the value read at byte offset 0 is vector `v`'s pending bit. Writes to the window are ignored.
- R8: The control register reads N-1 in bits 10:0, the function mask in bit 14 and the enable in bit 15. A control write loads bits 15 and 14.
- R9: The block answers only while memory decoding is enabled and the address lies in the table window (N·16 bytes) or the pending window. Each window's base is the base register chosen by location bits 2:0, plus the location with bits 2:0 cleared. Any other read returns all ones.
- R10: A request pulse sets the vector's pending bit while the enable is 1. It has no effect while the enable is 0.
- R11: A pending vector that is unmasked, with the enable set and the function mask clear, is sent as one message carrying its address and data. Sending it clears the pending bit. No message is sent while the enable is 0 or the function mask is 1.
- R12: A message appears one cycle after the write that unmasks a pending vector or clears the function mask. At most one message goes out per cycle, in ascending vector order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | input | 1 | Memory-space decoding enabled |
| bar_base | input | NUM_BAR·32 | Base addresses of all base registers, slot b at bits 32b+31:32b |
| tab_loc | input | 32 | Table location: bits 2:0 base-register select, rest offset |
| pba_loc | input | 32 | Pending-window location, same layout |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address of the access |
| acc_len | input | 4 | Access length in bytes |
| acc_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read result valid, one cycle after a read strobe |
| rd_data | output | 64 | Read result |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write value (bit 15 enable, bit 14 function mask) |
| ctl_rdata | output | 16 | Control register value |
| irq_req | input | N | Per-vector interrupt request |
| msg_valid | output | 1 | Message emitted this cycle |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The main delivery path is driven with three patterns. A request on a masked vector must stay pending until an unmask write releases it, which shows the mask gates sending and the one-cycle release timing. Several requests held back by the function mask are then released together, which separates ascending-order, one-per-cycle arbitration from any other order. A request with the enable off shows that the enable gates the setting of pending bits. The register side mixes random legal and illegal accesses, checked against a bench model of the table, with directed cases for partial address writes, the guarded 64-bit data write under each gate condition, the pending window and the window decode.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int ADDR_W = 32;
  localparam int ENTRY_BYTES = 16;

  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_VCTRL   = 2'd3
  } field_e;

  // Window base: selected base register plus location with select bits cleared
  function automatic logic [ADDR_W-1:0] win_base(input logic [ADDR_W-1:0] bar,
                                                 input logic [ADDR_W-1:3] loc_hi);
    return bar + {loc_hi, 3'b000};
  endfunction

  function automatic logic size_ok(input logic [2:0] a_lo, input logic [3:0] len);
    return (len == 4'd4 && a_lo[1:0] == 2'b00) || (len == 4'd8 && a_lo == 3'b000);
  endfunction

  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] base,
                                  input logic [ADDR_W:0]   bytes);
    logic [ADDR_W:0] lim;
    lim = {1'b0, base} + bytes;
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
  endfunction
endpackage

// File: rtl/msix_decode.sv
module msix_decode
  import msix_pkg::*;
#(
  parameter int N       = 4,
  parameter int NUM_BAR = 6,
  parameter int IW      = 2
) (
  input  logic                      mem_en,
  input  logic [NUM_BAR*ADDR_W-1:0] bar_base,
  input  logic [ADDR_W-1:0]         tab_loc,
  input  logic [ADDR_W-1:0]         pba_loc,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [3:0]                len,
  output logic                      legal,
  output logic                      hit_tab,
  output logic                      hit_pba,
  output logic [IW-1:0]             idx,
  output field_e                    field,
  output logic [2:0]                pba_byte
);
  localparam logic [ADDR_W:0] TAB_BYTES = (ADDR_W+1)'(N * ENTRY_BYTES);
  localparam logic [ADDR_W:0] PBA_BYTES = (ADDR_W+1)'((N + 7) / 8);

  logic [ADDR_W-1:0] tab_bar, pba_bar, tab_base, pba_base;
  logic [IW+3:0]     tab_off;

  always_comb begin
    tab_bar = '0;
    pba_bar = '0;
    for (int b = 0; b < NUM_BAR; b++) begin
      if (tab_loc[2:0] == 3'(b)) tab_bar = bar_base[b*ADDR_W +: ADDR_W];
      if (pba_loc[2:0] == 3'(b)) pba_bar = bar_base[b*ADDR_W +: ADDR_W];
    end
    tab_base = win_base(tab_bar, tab_loc[ADDR_W-1:3]);
    pba_base = win_base(pba_bar, pba_loc[ADDR_W-1:3]);
  end

  assign legal    = size_ok(addr[2:0], len);
  assign hit_tab  = mem_en && in_win(addr, tab_base, TAB_BYTES);
  assign hit_pba  = mem_en && in_win(addr, pba_base, PBA_BYTES);
  assign tab_off  = (IW+4)'(addr - tab_base);
  assign idx      = tab_off[IW+3:4];
  assign field    = field_e'(tab_off[3:2]);
  assign pba_byte = 3'(addr - pba_base);
endmodule

// File: rtl/msix_entry_store.sv
module msix_entry_store #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        sel,
  input  logic                 wr_lo,
  input  logic                 wr_full,
  input  logic                 wr_hi,
  input  logic                 wr_data,
  input  logic                 wr_mask,
  input  logic                 mask_val,
  input  logic [63:0]          wdata,
  output logic [N-1:0][63:0]   ent_addr,
  output logic [N-1:0][31:0]   ent_data,
  output logic [N-1:0]         ent_mask
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic        hit;
    logic [63:0] addr_q;
    logic [31:0] data_q;
    logic        mask_q;

    assign hit = (sel == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        data_q <= '0;
        mask_q <= 1'b1;
      end else if (hit) begin
        if (wr_full) addr_q <= wdata;
        if (wr_lo)   addr_q[31:0] <= wdata[31:0];
        if (wr_hi)   addr_q[63:32] <= wdata[31:0];
        if (wr_data) data_q <= wdata[31:0];
        if (wr_mask) mask_q <= mask_val;
      end
    end

    assign ent_addr[g] = addr_q;
    assign ent_data[g] = data_q;
    assign ent_mask[g] = mask_q;
  end
endmodule

// File: rtl/msix_issue.sv
module msix_issue #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       ready,
  input  logic [N-1:0][63:0] ent_addr,
  input  logic [N-1:0][31:0] ent_data,
  output logic [N-1:0]       clr,
  output logic               msg_valid,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  logic          found;
  logic [IW-1:0] pick;

  // Lowest-numbered ready vector wins
  always_comb begin
    clr   = '0;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ready[i] && !found) begin
        found  = 1'b1;
        clr[i] = 1'b1;
        pick   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= found;
      if (found) begin
        msg_addr <= ent_addr[pick];
        msg_data <= ent_data[pick];
      end
    end
  end
endmodule

// File: rtl/msix_vector_block.sv
module msix_vector_block
  import msix_pkg::*;
#(
  parameter int N       = 4,
  parameter int NUM_BAR = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mem_en,
  input  logic [NUM_BAR*ADDR_W-1:0] bar_base,
  input  logic [ADDR_W-1:0]         tab_loc,
  input  logic [ADDR_W-1:0]         pba_loc,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [3:0]                acc_len,
  input  logic [63:0]               acc_wdata,
  output logic                      rd_valid,
  output logic [63:0]               rd_data,
  input  logic                      ctl_we,
  input  logic [15:0]               ctl_wdata,
  output logic [15:0]               ctl_rdata,
  input  logic [N-1:0]              irq_req,
  output logic                      msg_valid,
  output logic [63:0]               msg_addr,
  output logic [31:0]               msg_data
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic               legal, hit_tab, hit_pba;
  logic [IW-1:0]      idx;
  field_e             field;
  logic [2:0]         pba_byte;
  logic [N-1:0][63:0] ent_addr;
  logic [N-1:0][31:0] ent_data;
  logic [N-1:0]       ent_mask;
  logic [N-1:0]       clr_vec, ready, pend_q;
  logic               en_q, fm_q;
  logic               len8, wr_go, guard_drop, rd_hit, rd_miss;
  logic               wr_lo, wr_full, wr_hi, wr_data, wr_mask, mask_val;
  logic [63:0]        tab_val, pba_val, raw_val, rd_d;
  logic               unused_ctl;

  assign unused_ctl = ^ctl_wdata[13:0];

  msix_decode #(.N(N), .NUM_BAR(NUM_BAR), .IW(IW)) u_dec (
    .mem_en(mem_en), .bar_base(bar_base), .tab_loc(tab_loc), .pba_loc(pba_loc),
    .addr(acc_addr), .len(acc_len), .legal(legal), .hit_tab(hit_tab),
    .hit_pba(hit_pba), .idx(idx), .field(field), .pba_byte(pba_byte)
  );

  // Write steering; the pending window takes priority and ignores writes
  assign len8       = (acc_len == 4'd8);
  assign wr_go      = acc_valid && acc_write && legal && hit_tab && !hit_pba;
  assign guard_drop = wr_go && field == FLD_DATA && len8 &&
                      !ent_mask[idx] && !fm_q && en_q;
  assign wr_lo      = wr_go && field == FLD_ADDR_LO && !len8;
  assign wr_full    = wr_go && field == FLD_ADDR_LO && len8;
  assign wr_hi      = wr_go && field == FLD_ADDR_HI;
  assign wr_data    = wr_go && field == FLD_DATA && !guard_drop;
  assign wr_mask    = (wr_go && field == FLD_VCTRL) || (wr_data && len8);
  assign mask_val   = (field == FLD_VCTRL) ? acc_wdata[0] : acc_wdata[32];

  msix_entry_store #(.N(N), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .sel(idx), .wr_lo(wr_lo), .wr_full(wr_full),
    .wr_hi(wr_hi), .wr_data(wr_data), .wr_mask(wr_mask), .mask_val(mask_val),
    .wdata(acc_wdata), .ent_addr(ent_addr), .ent_data(ent_data), .ent_mask(ent_mask)
  );

  // Control and pending state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fm_q   <= 1'b0;
      pend_q <= '0;
    end else begin
      if (ctl_we) begin
        en_q <= ctl_wdata[15];
        fm_q <= ctl_wdata[14];
      end
      pend_q <= (pend_q & ~clr_vec) | (irq_req & {N{en_q}});
    end
  end

  assign ctl_rdata = {en_q, fm_q, 3'b000, 11'(N - 1)};
  assign ready     = pend_q & ~ent_mask & {N{en_q && !fm_q}};

  msix_issue #(.N(N), .IW(IW)) u_issue (
    .clk(clk), .rst_n(rst_n), .ready(ready), .ent_addr(ent_addr),
    .ent_data(ent_data), .clr(clr_vec), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // Read path
  always_comb begin
    case (field)
      FLD_ADDR_LO: tab_val = len8 ? ent_addr[idx] : {32'h0, ent_addr[idx][31:0]};
      FLD_ADDR_HI: tab_val = {32'h0, ent_addr[idx][63:32]};
      FLD_DATA:    tab_val = {31'h0, len8 && ent_mask[idx], ent_data[idx]};
      default:     tab_val = {63'h0, ent_mask[idx]};
    endcase
    pba_val = 64'(pend_q) >> {pba_byte, 3'b000};
    raw_val = hit_pba ? pba_val : tab_val;
    if (!len8) raw_val[63:32] = 32'h0;
  end

  assign rd_hit  = legal && (hit_tab || hit_pba);
  assign rd_miss = acc_valid && !acc_write && !rd_hit;
  assign rd_d    = rd_hit ? raw_val : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= rd_d;
    end
  end
endmodule

// File: rtl/msix_vector_block_chk.sv
module msix_vector_block_chk #(
  parameter int N = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               fm,
  input logic               msg_valid,
  input logic [N-1:0]       clr,
  input logic               guard_drop,
  input logic [N-1:0][31:0] ent_data,
  input logic               rd_valid,
  input logic [63:0]        rd_data,
  input logic               rd_miss
);
  // R11: a message only leaves when the previous cycle allowed sending
  assert_msg_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(en && !fm));

  // R12: at most one vector is served per cycle
  assert_one_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));

  // R5: a blocked combined write leaves every data word untouched
  assert_guard_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    guard_drop |=> $stable(ent_data));

  // R1 / R9: a read outside the windows or with a bad size returns all ones
  assert_miss_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_miss)) |-> (rd_data == 64'hFFFF_FFFF_FFFF_FFFF));
endmodule

bind msix_vector_block msix_vector_block_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .fm(fm_q), .msg_valid(msg_valid),
  .clr(clr_vec), .guard_drop(guard_drop), .ent_data(ent_data),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_miss(rd_miss)
);

// File: tb/sim_msix_vector_block.sv
module sim_msix_vector_block;
  localparam int N  = 4;
  localparam int NB = 6;
  localparam logic [31:0] TB    = 32'h4000_1000;
  localparam logic [31:0] PB    = 32'h4000_2000;
  localparam logic [31:0] PBA_B = 32'((N + 7) / 8);
  localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_en = 1'b0;
  logic [NB*32-1:0] bar_base = '0;
  logic [31:0] tab_loc = 32'h0000_1002;
  logic [31:0] pba_loc = 32'h0000_2002;
  logic acc_valid = 1'b0;
  logic acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [3:0] acc_len = '0;
  logic [63:0] acc_wdata = '0;
  logic rd_valid;
  logic [63:0] rd_data;
  logic ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic [N-1:0] irq_req = '0;
  logic msg_valid;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  always #2 clk = ~clk;

  msix_vector_block #(.N(N), .NUM_BAR(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .bar_base(bar_base),
    .tab_loc(tab_loc), .pba_loc(pba_loc), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_len(acc_len),
    .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .irq_req(irq_req), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int n_msg = 0;
  logic [63:0] l_addr [16];
  logic [31:0] l_data [16];
  int          l_cyc  [16];

  // Bench model of the table
  logic [63:0] m_addr [N];
  logic [31:0] m_data [N];
  logic        m_mask [N];
  logic        m_en = 1'b0;
  logic        m_fm = 1'b0;
  logic [N-1:0] m_pend = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (msg_valid && n_msg < 16) begin
      l_addr[n_msg] = msg_addr;
      l_data[n_msg] = msg_data;
      l_cyc[n_msg]  = cyc;
      n_msg = n_msg + 1;
    end
  end

  function automatic bit legal_acc(input logic [31:0] a, input logic [3:0] len);
    return (len == 4'd4 && a[1:0] == 2'b00) || (len == 4'd8 && a[2:0] == 3'b000);
  endfunction

  function automatic bit in_pba(input logic [31:0] a);
    return a >= PB && a < PB + PBA_B;
  endfunction

  function automatic bit in_tab(input logic [31:0] a);
    return a >= TB && a < TB + 32'(N * 16);
  endfunction

  function automatic logic [63:0] exp_rd(input logic [31:0] a, input logic [3:0] len);
    logic [63:0] v;
    int e, o;
    if (!mem_en || !legal_acc(a, len)) return ONES;
    if (in_pba(a)) begin
      v = 64'(m_pend) >> (8 * int'(a - PB));
    end else if (in_tab(a)) begin
      e = int'((a - TB) >> 4);
      o = int'((a - TB) & 32'hF);
      case (o)
        0:       v = m_addr[e];
        4:       v = {32'h0, m_addr[e][63:32]};
        8:       v = {31'h0, m_mask[e], m_data[e]};
        default: v = {63'h0, m_mask[e]};
      endcase
    end else begin
      return ONES;
    end
    if (len == 4'd4) v[63:32] = 32'h0;
    return v;
  endfunction

  function automatic void model_wr(input logic [31:0] a, input logic [3:0] len,
                                   input logic [63:0] d);
    int e, o;
    if (!mem_en || !legal_acc(a, len) || in_pba(a) || !in_tab(a)) return;
    e = int'((a - TB) >> 4);
    o = int'((a - TB) & 32'hF);
    case (o)
      0: if (len == 4'd8) m_addr[e] = d; else m_addr[e][31:0] = d[31:0];
      4: m_addr[e][63:32] = d[31:0];
      8: if (!(len == 4'd8 && !m_mask[e] && !m_fm && m_en)) begin
           m_data[e] = d[31:0];
           if (len == 4'd8) m_mask[e] = d[32];
         end
      default: m_mask[e] = d[0];
    endcase
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic bus(input bit w, input logic [31:0] a, input logic [3:0] len,
                     input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_len = len; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    r = rd_data;
  endtask

  task automatic wr(input logic [31:0] a, input logic [3:0] len, input logic [63:0] d);
    logic [63:0] r;
    model_wr(a, len, d);
    bus(1'b1, a, len, d, r);
  endtask

  task automatic rd(input logic [31:0] a, input logic [3:0] len, output logic [63:0] r);
    bus(1'b0, a, len, 64'h0, r);
  endtask

  task automatic rd_model(input string what, input logic [31:0] a, input logic [3:0] len);
    logic [63:0] r;
    rd(a, len, r);
    chk(what, r, exp_rd(a, len));
  endtask

  task automatic ctl(input logic en, input logic fm);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = {en, fm, 14'h0};
    @(negedge clk);
    ctl_we = 1'b0;
    m_en = en; m_fm = fm;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    irq_req = '0;
    if (m_en) m_pend = m_pend | v;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [63:0] r;
    int base;
    void'($urandom(32'd7341));
    for (int v = 0; v < N; v++) begin
      m_addr[v] = '0; m_data[v] = '0; m_mask[v] = 1'b1;
    end
    bar_base[2*32 +: 32] = 32'h4000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mem_en = 1'b1;

    // R6 / R8: reset state
    for (int v = 0; v < N; v++) begin
      rd(TB + 32'(16 * v + 12), 4'd4, r);
      chk("R6 vector masked after reset", r, 64'h1);
    end
    rd(TB + 32'd8, 4'd8, r);
    chk("R6 data and mask after reset", r, 64'h0000_0001_0000_0000);
    chk("R8 control after reset", 64'(ctl_rdata), 64'h0003);
    rd(PB, 4'd4, r);
    chk("R7 no pending after reset", r, 64'h0);

    // R3 / R2: address words
    wr(TB, 4'd8, 64'h1111_2222_3333_4444);
    rd(TB, 4'd8, r);
    chk("R3 full address write", r, 64'h1111_2222_3333_4444);
    wr(TB, 4'd4, 64'h0000_0000_AAAA_BBBB);
    rd(TB, 4'd8, r);
    chk("R3 low word write keeps high", r, 64'h1111_2222_AAAA_BBBB);
    rd(TB + 32'd4, 4'd4, r);
    chk("R2 high word at offset 4", r, 64'h1111_2222);

    // R1: size and alignment
    rd(TB, 4'd2, r);
    chk("R1 two-byte read", r, ONES);
    rd(TB + 32'd4, 4'd8, r);
    chk("R1 misaligned 8-byte read", r, ONES);
    wr(TB + 32'd4, 4'd8, 64'h5);
    rd(TB + 32'd4, 4'd4, r);
    chk("R1 misaligned write dropped", r, 64'h1111_2222);

    // R9: decode
    mem_en = 1'b0;
    rd(TB, 4'd4, r);
    chk("R9 decode disabled", r, ONES);
    mem_en = 1'b1;
    rd(TB + 32'(N * 16), 4'd4, r);
    chk("R9 past table end", r, ONES);
    bar_base[2*32 +: 32] = 32'h5000_0000;
    rd(32'h5000_1000, 4'd4, r);
    chk("R9 window follows base register", r, 64'hAAAA_BBBB);
    bar_base[2*32 +: 32] = 32'h4000_0000;

    // R7: pending window ignores writes
    wr(PB, 4'd4, 64'hFFFF_FFFF);
    rd(PB, 4'd4, r);
    chk("R7 pending write ignored", r, 64'h0);

    // R10: requests ignored while disabled
    ctl(1'b0, 1'b0);
    pulse({N{1'b1}});
    rd(PB, 4'd4, r);
    chk("R10 request while disabled", r, 64'h0);

    // R10 / R11 / R12: masked vector released by unmask
    ctl(1'b1, 1'b0);
    wr(TB + 32'd16, 4'd8, 64'h0000_0001_FEE0_1000);
    wr(TB + 32'd24, 4'd4, 64'h41);
    wr(TB + 32'd28, 4'd4, 64'h1);
    pulse(4'b0010);
    rd(PB, 4'd4, r);
    chk("R10 pending set", r, 64'h2);
    chk("R11 masked vector holds", 64'(n_msg), 64'd0);
    wr(TB + 32'd28, 4'd4, 64'h0);
    chk("R12 no message in write cycle", 64'(n_msg), 64'd0);
    @(negedge clk);
    chk("R12 message one cycle after unmask", 64'(n_msg), 64'd1);
    chk("R11 message address", l_addr[0], 64'h0000_0001_FEE0_1000);
    chk("R11 message data", 64'(l_data[0]), 64'h41);
    m_pend = '0;
    rd(PB, 4'd4, r);
    chk("R11 pending cleared", r, 64'h0);

    // R12: ordering after function mask release
    ctl(1'b1, 1'b1);
    for (int v = 0; v < N; v++) begin
      if (v != 1) begin
        wr(TB + 32'(16 * v), 4'd8, 64'h0000_0002_0000_0000 | 64'(v * 16));
        wr(TB + 32'(16 * v + 8), 4'd4, 64'(32'h50 + 32'(v)));
        wr(TB + 32'(16 * v + 12), 4'd4, 64'h0);
      end
    end
    pulse(4'b1101);
    rd(PB, 4'd4, r);
    chk("R10 three pending", r, 64'hD);
    chk("R11 function mask holds", 64'(n_msg), 64'd1);
    base = n_msg;
    ctl(1'b1, 1'b0);
    chk("R12 none in release cycle", 64'(n_msg), 64'(base));
    @(negedge clk);
    chk("R12 first one cycle after release", 64'(n_msg), 64'(base + 1));
    repeat (3) @(negedge clk);
    chk("R12 three messages total", 64'(n_msg), 64'(base + 3));
    chk("R12 order first", 64'(l_data[base]), 64'h50);
    chk("R12 order second", 64'(l_data[base+1]), 64'h52);
    chk("R12 order third", 64'(l_data[base+2]), 64'h53);
    chk("R11 third address", l_addr[base+2], 64'h0000_0002_0000_0030);
    chk("R12 one per cycle", 64'(l_cyc[base+2] - l_cyc[base]), 64'd2);
    m_pend = '0;

    // R5 / R4: guarded combined write
    wr(TB + 32'd8, 4'd8, 64'h0000_0001_0000_1234);
    rd(TB + 32'd8, 4'd8, r);
    chk("R5 live vector write discarded", r, 64'h0000_0000_0000_0050);
    ctl(1'b1, 1'b1);
    wr(TB + 32'd8, 4'd8, 64'h0000_0001_0000_5678);
    rd(TB + 32'd8, 4'd8, r);
    chk("R4 data and control read", r, 64'h0000_0001_0000_5678);
    chk("R8 control enable and mask", 64'(ctl_rdata), 64'hC003);
    ctl(1'b1, 1'b0);
    wr(TB + 32'd8, 4'd8, 64'h0000_0000_0000_9ABC);
    rd(TB + 32'd8, 4'd8, r);
    chk("R5 masked vector accepts", r, 64'h0000_0000_0000_9ABC);
    ctl(1'b0, 1'b0);
    wr(TB + 32'd8, 4'd8, 64'h0000_0000_0000_7777);
    rd(TB + 32'd12, 4'd4, r);
    chk("R5 disabled accepts mask", r, 64'h0);
    rd(TB + 32'd8, 4'd4, r);
    chk("R5 disabled accepts data", r, 64'h7777);
    chk("R11 no stray messages", 64'(n_msg), 64'(base + 3));

    // R2: random accesses against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rr;
      logic [31:0] a;
      logic [3:0]  len;
      rr = $urandom;
      case (rr[9:8])
        2'd0:    len = 4'd4;
        2'd3:    len = 4'd2;
        default: len = 4'd8;
      endcase
      if (rr[12:10] == 3'd0) a = PB + (rr[2] ? 32'd4 : 32'd0);
      else a = TB + ((rr[31:16] % 32'(N * 16 + 16)) & 32'hFFFF_FFFC);
      if (rr[14:13] == 2'd0) ctl(rr[15], rr[3]);
      if (rr[13]) wr(a, len, {$urandom, $urandom});
      rd_model("R2 random table access", a, len);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule